// File: doc/BRIEF.md
# Byte-to-Word Data FIFO Engine

This block sits between a host-side word FIFO and a byte-wide card data path. A 16-entry FIFO of 32-bit words is filled or drained by the host through two stream ports. A transfer engine moves the data to or from the card one byte per clock. Software-style control is reduced to two plain register write strobes. One strobe loads a 16-bit transfer length. The other loads an 8-bit transfer-control value, whose enable bit starts a byte down-counter at that length.

When the transfer runs from card to host, incoming card bytes are packed into words starting at the least significant byte. A word is pushed once four bytes have arrived, or sooner, zero-padded, when the last byte of the transfer arrives. When the transfer runs from host to card, each popped word is sent as four bytes, least significant first. The block reports end-of-data and a group of FIFO occupancy flags. Only the group that belongs to the current direction is reported. The engine turns its own enable bit off once the byte count is zero and the FIFO is empty.

Stream rules: a transfer happens on a rising edge where valid and ready are both high. The host push port (`h_in_*`) is ready only in the host-to-card direction while the FIFO has room. The host pop port (`h_out_*`) is valid only in the card-to-host direction while the FIFO holds data. The card receive port (`c_rx_*`) is ready only while the engine runs, the count is non-zero and the FIFO is not full. The card transmit port (`c_tx_*`) has no back-pressure: the card takes a byte on every edge where `c_tx_valid` is high. Valid never depends on ready.

Top module: `xfer_byte_word_engine`

## Requirements
- R1: After reset, `ctrl_q`, `byte_cnt` and `status` are zero, `h_out_valid`, `c_tx_valid` and `c_rx_ready` are low, and `h_out_data` is zero.
- R2: A control write stores all 8 bits in `ctrl_q`. Bit 0 is enable, bit 1 is direction (1 = card to host), bit 2 is mode and bit 3 is DMA-enable. A write with bit 0 set copies the length register into `byte_cnt`. Mode and DMA-enable are stored but change no transfer behaviour.
- R3: The FIFO holds 16 words. A push offered while it is full is not taken (`h_in_ready` low) and leaves the contents unchanged. While it is empty, `h_out_valid` is low and `h_out_data` reads zero.
- R4: In card-to-host mode, card bytes fill a word from bits [7:0] upward. A byte is taken only when `c_rx_valid` is high, the count is non-zero and the FIFO is not full. Each byte taken lowers `byte_cnt` by one.
- R5: When the final byte of a transfer completes a word only partly, that word is still pushed, with its unused upper bytes zero.
- R6: In host-to-card mode, a word is popped and sent over four cycles, bits [7:0] first. Each byte sent lowers `byte_cnt` by one, and bytes left over when the count reaches zero are dropped.
- R7: `status[8]` (data end) and `status[10]` (block end) become set one cycle after the engine is enabled with `byte_cnt` at zero. They stay set until the next control write that has the enable bit set.
- R8: When the engine is enabled, `byte_cnt` is zero and the FIFO is empty, `ctrl_q[0]` clears on the next edge. The other control bits are kept.
- R9: FIFO flags are reported only while the engine is enabled and still has work to do. A transmit group uses even bits and a receive group uses odd bits: active 12/13, half-empty 14 (occupancy at most 8, transmit only), half-full 15 (occupancy at least 8, receive only), full 16/17 (occupancy 16), empty 18/19 (occupancy 0), data available 20/21 (occupancy above 0).
- R10: Only the group selected by the direction bit is ever non-zero. Both groups read zero while the engine is disabled.
- R11: At most one card byte moves per clock, and the receive and transmit card ports are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control value to write |
| len_wr | input | 1 | Length register write strobe |
| len_wdata | input | LEN_W | Transfer length in bytes |
| ctrl_q | output | 8 | Current control value, including the self-clearing enable |
| byte_cnt | output | LEN_W | Bytes remaining in the transfer |
| status | output | 22 | End-of-data bits and direction-qualified FIFO flags |
| h_in_valid | input | 1 | Host push word valid |
| h_in_ready | output | 1 | FIFO accepts a host word |
| h_in_data | input | WORD_W | Host word to push |
| h_out_valid | output | 1 | FIFO head available to host |
| h_out_ready | input | 1 | Host takes the head word |
| h_out_data | output | WORD_W | Head word, zero when nothing is offered |
| c_rx_valid | input | 1 | Card has a byte ready |
| c_rx_ready | output | 1 | Engine takes the card byte |
| c_rx_data | input | 8 | Byte from the card |
| c_tx_valid | output | 1 | Byte to the card this cycle |
| c_tx_data | output | 8 | Byte to the card |

## Verification
The bench builds the block with its default parameters: 16 words of 32 bits and a 16-bit length. With those values, a 68-byte write and an 80-byte read take the FIFO to its full boundary. The first proves that a seventeenth host word is refused. The second proves that the card port stalls at exactly 64 bytes, and that the half-full flag flips between occupancy 8 and 7 as the host drains. Lengths of 0, 4, 5 and 6 exercise the empty transfer, the exact-word end and the partial final word in both directions. Random lengths up to 70 bytes, under random valid and ready timing, cover every lane position at the end of a transfer.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
  localparam int CTL_EN   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_MODE = 2;
  localparam int CTL_DMA  = 3;

  localparam int ST_W        = 22;
  localparam int ST_DATA_END = 8;
  localparam int ST_BLK_END  = 10;
  localparam int ST_GRP_BASE = 12;
  localparam int GRP_BITS    = 10;

  typedef enum logic {
    XBW_TO_CARD   = 1'b0,
    XBW_FROM_CARD = 1'b1
  } xbw_dir_e;

  typedef struct packed {
    logic avail;
    logic empty;
    logic full;
    logic half;
    logic active;
  } xbw_grp_t;
endpackage

// File: rtl/xbw_word_fifo.sv
module xbw_word_fifo #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_req,
  input  logic [WORD_W-1:0]           push_data,
  input  logic                        pop_req,
  output logic [WORD_W-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0]  occ,
  output logic                        full,
  output logic                        empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH+1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_idx;
  logic              do_push, do_pop;

  assign full    = (occ == OCC_W'(DEPTH));
  assign empty   = (occ == '0);
  assign do_push = push_req & ~full;
  assign do_pop  = pop_req & ~empty;
  assign wr_idx  = rd_ptr + PTR_W'(occ);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_pop) rd_ptr <= rd_ptr + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/xbw_lane_engine.sv
module xbw_lane_engine #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic              dir,
  input  logic              cnt_nz,
  input  logic              cnt_one,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_head,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              push_req,
  output logic [WORD_W-1:0] push_word,
  output logic              pop_req,
  output logic              step
);
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [WORD_W-1:0] acc, txw;
  logic [LANE_W-1:0] nb;
  logic [LANE_W:0]   txn;
  logic              rx_take;

  assign rx_ready = run & dir & cnt_nz & ~fifo_full;
  assign rx_take  = rx_ready & rx_valid;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign push_word[l*8 +: 8] = (nb == LANE_W'(l)) ? rx_data : acc[l*8 +: 8];
  end

  assign push_req = rx_take & ((nb == LANE_W'(LANES-1)) | cnt_one);
  assign tx_valid = run & ~dir & cnt_nz & ((txn != '0) | ~fifo_empty);
  assign pop_req  = tx_valid & (txn == '0);
  assign tx_data  = (txn == '0) ? fifo_head[7:0] : txw[7:0];
  assign step     = rx_take | tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      nb  <= '0;
      txw <= '0;
      txn <= '0;
    end else if (restart) begin
      acc <= '0;
      nb  <= '0;
      txw <= '0;
      txn <= '0;
    end else begin
      if (rx_take) begin
        if (push_req) begin
          acc <= '0;
          nb  <= '0;
        end else begin
          acc <= push_word;
          nb  <= nb + LANE_W'(1);
        end
      end
      if (tx_valid) begin
        if (txn == '0) begin
          txw <= fifo_head >> 8;
          txn <= (LANE_W+1)'(LANES-1);
        end else begin
          txw <= txw >> 8;
          txn <= txn - (LANE_W+1)'(1);
        end
      end
    end
  end
endmodule

// File: rtl/xbw_flag_gen.sv
module xbw_flag_gen
  import xbw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OCC_W = 5
) (
  input  logic [OCC_W-1:0]    occ,
  input  logic                dir,
  input  logic                show,
  output logic [GRP_BITS-1:0] grp_bits
);
  localparam int HALF = DEPTH / 2;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    xbw_grp_t g;
    logic     sel;
    assign sel = show & (dir == d[0]);
    always_comb begin
      g.active = 1'b1;
      g.half   = (d == 1) ? (occ >= OCC_W'(HALF)) : (occ <= OCC_W'(HALF));
      g.full   = (occ == OCC_W'(DEPTH));
      g.empty  = (occ == '0);
      g.avail  = (occ != '0);
    end
    assign grp_bits[0+d] = sel & g.active;
    assign grp_bits[2+d] = sel & g.half;
    assign grp_bits[4+d] = sel & g.full;
    assign grp_bits[6+d] = sel & g.empty;
    assign grp_bits[8+d] = sel & g.avail;
  end
endmodule

// File: rtl/xfer_byte_word_engine.sv
module xfer_byte_word_engine
  import xbw_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_wdata,
  output logic [7:0]        ctrl_q,
  output logic [LEN_W-1:0]  byte_cnt,
  output logic [ST_W-1:0]   status,
  input  logic              h_in_valid,
  output logic              h_in_ready,
  input  logic [WORD_W-1:0] h_in_data,
  output logic              h_out_valid,
  input  logic              h_out_ready,
  output logic [WORD_W-1:0] h_out_data,
  input  logic              c_rx_valid,
  output logic              c_rx_ready,
  input  logic [7:0]        c_rx_data,
  output logic              c_tx_valid,
  output logic [7:0]        c_tx_data
);
  localparam int OCC_W = $clog2(DEPTH+1);

  logic [LEN_W-1:0]  len_q;
  logic              end_q;
  logic [OCC_W-1:0]  fifo_occ;
  logic              fifo_full, fifo_empty;
  logic [WORD_W-1:0] fifo_head, eng_word;
  logic              eng_push, eng_pop, eng_step;
  logic              restart, run, show, cnt_zero;
  logic [GRP_BITS-1:0] grp_bits;
  xbw_dir_e          dir;

  assign dir      = xbw_dir_e'(ctrl_q[CTL_DIR]);
  assign cnt_zero = (byte_cnt == '0);
  assign restart  = ctrl_wr & ctrl_wdata[CTL_EN];
  assign run      = ctrl_q[CTL_EN] & ~ctrl_wr;
  assign show     = ctrl_q[CTL_EN] & ~(cnt_zero & fifo_empty);

  assign h_in_ready  = (dir == XBW_TO_CARD) & ~fifo_full;
  assign h_out_valid = (dir == XBW_FROM_CARD) & ~fifo_empty;
  assign h_out_data  = h_out_valid ? fifo_head : '0;

  xbw_word_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (eng_push | (h_in_valid & h_in_ready)),
    .push_data ((dir == XBW_FROM_CARD) ? eng_word : h_in_data),
    .pop_req   (eng_pop | (h_out_valid & h_out_ready)),
    .head      (fifo_head),
    .occ       (fifo_occ),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  xbw_lane_engine #(.WORD_W(WORD_W)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .run        (run),
    .dir        (ctrl_q[CTL_DIR]),
    .cnt_nz     (~cnt_zero),
    .cnt_one    (byte_cnt == LEN_W'(1)),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_head  (fifo_head),
    .rx_valid   (c_rx_valid),
    .rx_data    (c_rx_data),
    .rx_ready   (c_rx_ready),
    .tx_valid   (c_tx_valid),
    .tx_data    (c_tx_data),
    .push_req   (eng_push),
    .push_word  (eng_word),
    .pop_req    (eng_pop),
    .step       (eng_step)
  );

  xbw_flag_gen #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_flags (
    .occ      (fifo_occ),
    .dir      (ctrl_q[CTL_DIR]),
    .show     (show),
    .grp_bits (grp_bits)
  );

  always_comb begin
    status = '0;
    status[ST_DATA_END] = end_q;
    status[ST_BLK_END]  = end_q;
    status[ST_GRP_BASE +: GRP_BITS] = grp_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      len_q    <= '0;
      byte_cnt <= '0;
      end_q    <= 1'b0;
    end else begin
      if (len_wr) len_q <= len_wdata;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_wdata;
        if (ctrl_wdata[CTL_EN]) begin
          byte_cnt <= len_q;
          end_q    <= 1'b0;
        end
      end else begin
        if (eng_step) byte_cnt <= byte_cnt - LEN_W'(1);
        if (ctrl_q[CTL_EN] & cnt_zero) begin
          end_q <= 1'b1;
          if (fifo_empty) ctrl_q[CTL_EN] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/xbw_checker.sv
module xbw_checker #(
  parameter int LEN_W = 16,
  parameter int OCC_W = 5,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic [7:0]        ctrl_q,
  input logic [LEN_W-1:0]  byte_cnt,
  input logic [21:0]       status,
  input logic              h_in_ready,
  input logic              h_out_valid,
  input logic [WORD_W-1:0] h_out_data,
  input logic              c_rx_valid,
  input logic              c_rx_ready,
  input logic              c_tx_valid,
  input logic [OCC_W-1:0]  occ
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[16] |-> !h_in_ready);

  p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (!h_out_valid && h_out_data == '0));

  p_rx_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[17] |-> !c_rx_ready);

  p_rx_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rx_valid && c_rx_ready) |=> (byte_cnt == $past(byte_cnt) - LEN_W'(1)));

  p_tx_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_tx_valid |=> (byte_cnt == $past(byte_cnt) - LEN_W'(1)));

  p_end_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && byte_cnt == '0 && !ctrl_wr) |=> (status[8] && status[10]));

  p_self_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && byte_cnt == '0 && occ == '0 && !ctrl_wr) |=> !ctrl_q[0]);

  p_one_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[12] && status[13]));

  p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_tx_valid && c_rx_ready));
endmodule

bind xfer_byte_word_engine xbw_checker #(.LEN_W(LEN_W), .OCC_W(OCC_W), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_wr     (ctrl_wr),
  .ctrl_q      (ctrl_q),
  .byte_cnt    (byte_cnt),
  .status      (status),
  .h_in_ready  (h_in_ready),
  .h_out_valid (h_out_valid),
  .h_out_data  (h_out_data),
  .c_rx_valid  (c_rx_valid),
  .c_rx_ready  (c_rx_ready),
  .c_tx_valid  (c_tx_valid),
  .occ         (fifo_occ)
);

// File: tb/sim_xfer_byte_word_engine.sv
module sim_xfer_byte_word_engine;
  localparam logic [31:0] ST_TX_IDLE = 32'h045000;
  localparam logic [31:0] ST_RX_EMPTY = 32'h082000;
  localparam logic [31:0] ST_RX_FULL = 32'h22A000;
  localparam logic [31:0] ST_RX_HALF = 32'h20A000;
  localparam logic [31:0] ST_RX_LOW = 32'h202000;
  localparam logic [31:0] ST_END = 32'h000500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 0, len_wr = 0;
  logic [7:0] ctrl_wdata = 0;
  logic [15:0] len_wdata = 0;
  logic [7:0] ctrl_q;
  logic [15:0] byte_cnt;
  logic [21:0] status;
  logic h_in_valid = 0, h_in_ready, h_out_valid, h_out_ready = 0;
  logic [31:0] h_in_data = 0, h_out_data;
  logic c_rx_valid = 0, c_rx_ready, c_tx_valid;
  logic [7:0] c_rx_data = 0, c_tx_data;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  xfer_byte_word_engine u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_of(logic [31:0] w, int k);
    return 8'(w >> (8 * k));
  endfunction

  function automatic logic [31:0] word_of(logic [7:0] q[$], int base, int len);
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++)
      if (base + l < len) w |= 32'(q[base + l]) << (8 * l);
    return w;
  endfunction

  task automatic wr_len(logic [15:0] v);
    len_wr = 1; len_wdata = v; @(negedge clk); len_wr = 0;
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_wr = 1; ctrl_wdata = v; @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic run_rx(int len, int pv, int pr, logic [7:0] mb);
    logic [7:0] b[$];
    int nw = (len + 3) / 4, bi = 0, wi = 0, guard = 0;
    for (int k = 0; k < len; k++) b.push_back(8'($urandom));
    wr_len(16'(len)); wr_ctrl(8'h03 | mb);
    while (wi < nw && guard < 4000) begin
      c_rx_valid = (bi < len) && ($urandom % 100 < pv);
      c_rx_data = c_rx_valid ? b[bi] : 8'h00;
      h_out_ready = ($urandom % 100 < pr);
      #1;
      if (c_rx_valid && c_rx_ready) bi++;
      if (h_out_valid && h_out_ready) begin
        chk((wi == nw - 1 && len % 4 != 0) ? "R5 partial word" : "R4 packed word",
            h_out_data, word_of(b, 4 * wi, len));
        wi++;
      end
      guard++;
      @(negedge clk);
    end
    c_rx_valid = 0; h_out_ready = 0;
    chk("R4 all words popped", 32'(wi), 32'(nw));
    repeat (2) @(negedge clk);
    chk("R8 engine off after read", 32'(ctrl_q), 32'(8'h02 | mb));
    chk("R7 end flags after read", 32'(status), ST_END);
  endtask

  task automatic run_tx(int len, int pv, logic [7:0] mb);
    logic [31:0] w[$];
    int nw = (len + 3) / 4, bi = 0, wi = 0, guard = 0;
    for (int k = 0; k < nw; k++) w.push_back($urandom);
    wr_len(16'(len)); wr_ctrl(8'h01 | mb);
    while (bi < len && guard < 4000) begin
      h_in_valid = (wi < nw) && ($urandom % 100 < pv);
      h_in_data = (wi < nw) ? w[wi] : 32'h0;
      #1;
      if (h_in_valid && h_in_ready) wi++;
      if (c_tx_valid) begin
        chk("R6 card byte order", 32'(c_tx_data), 32'(lane_of(w[bi / 4], bi % 4)));
        bi++;
      end
      guard++;
      @(negedge clk);
    end
    h_in_valid = 0;
    chk("R6 bytes sent", 32'(bi), 32'(len));
    repeat (2) @(negedge clk);
    chk("R11 no extra byte", 32'(c_tx_valid), 32'h0);
    chk("R8 engine off after write", 32'(ctrl_q), 32'(mb));
    chk("R7 end flags after write", 32'(status), ST_END);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] fw[17];
    logic [7:0] rb[$];
    int i, bi, wi, guard;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl_q), 0);
    chk("R1 count", 32'(byte_cnt), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 ports", {h_out_valid, c_tx_valid, c_rx_ready}, 0);
    chk("R1 pop data", h_out_data, 0);

    // R2 storage and load; R9/R10 transmit idle flags
    wr_len(16'd40); wr_ctrl(8'h0C);
    chk("R2 ctrl stored", 32'(ctrl_q), 32'h0C);
    chk("R2 no load without enable", 32'(byte_cnt), 0);
    chk("R10 flags zero while disabled", 32'(status), 0);
    wr_ctrl(8'h0D);
    chk("R2 count loaded", 32'(byte_cnt), 40);
    chk("R9 transmit empty flags", 32'(status), ST_TX_IDLE);
    wr_ctrl(8'h00);

    // R3 full FIFO refuses a push
    for (int k = 0; k < 17; k++) fw[k] = $urandom;
    i = 0;
    repeat (17) begin
      h_in_valid = 1; h_in_data = fw[i]; #1;
      if (h_in_ready) i++;
      @(negedge clk);
    end
    h_in_valid = 0;
    chk("R3 words accepted", 32'(i), 16);
    chk("R3 ready low when full", 32'(h_in_ready), 0);
    wr_len(16'd68); wr_ctrl(8'h01);
    bi = 0;
    repeat (80) begin
      #1;
      if (c_tx_valid) begin
        chk("R6 byte from full fifo", 32'(c_tx_data), 32'(lane_of(fw[bi / 4], bi % 4)));
        bi++;
      end
      @(negedge clk);
    end
    chk("R3 only 16 words sent", 32'(bi), 64);
    chk("R6 count left", 32'(byte_cnt), 4);
    chk("R8 still enabled", 32'(ctrl_q), 32'h01);
    chk("R9 transmit starved flags", 32'(status), ST_TX_IDLE);
    h_in_valid = 1; h_in_data = fw[16];
    @(negedge clk);
    h_in_valid = 0;
    repeat (8) begin
      #1;
      if (c_tx_valid) begin
        chk("R6 last word bytes", 32'(c_tx_data), 32'(lane_of(fw[16], bi - 64)));
        bi++;
      end
      @(negedge clk);
    end
    chk("R6 total bytes", 32'(bi), 68);
    chk("R8 off after write", 32'(ctrl_q), 0);
    chk("R7 end flags", 32'(status), ST_END);

    // R4/R9 receive: pause at full, flags at boundaries
    for (int k = 0; k < 80; k++) rb.push_back(8'($urandom));
    wr_len(16'd80); wr_ctrl(8'h03);
    chk("R7 end flags cleared by enable", 32'(status[8]), 0);
    chk("R9 receive empty flags", 32'(status), ST_RX_EMPTY);
    chk("R3 empty pop data zero", h_out_data, 0);
    chk("R3 empty pop not valid", 32'(h_out_valid), 0);
    bi = 0;
    repeat (70) begin
      c_rx_valid = 1; c_rx_data = rb[bi]; #1;
      if (c_rx_ready) bi++;
      @(negedge clk);
    end
    c_rx_valid = 0;
    chk("R4 pause at full", 32'(bi), 64);
    chk("R4 ready low at full", 32'(c_rx_ready), 0);
    chk("R4 count at pause", 32'(byte_cnt), 16);
    chk("R9 receive full flags", 32'(status), ST_RX_FULL);
    wi = 0;
    for (int p = 0; p < 9; p++) begin
      h_out_ready = 1; #1;
      chk("R4 popped word", h_out_data, word_of(rb, 4 * wi, 80));
      wi++;
      @(negedge clk);
      h_out_ready = 0;
      if (wi == 8) chk("R9 half-full at 8", 32'(status), ST_RX_HALF);
    end
    chk("R9 below half at 7", 32'(status), ST_RX_LOW);
    guard = 0;
    while (wi < 20 && guard < 500) begin
      c_rx_valid = (bi < 80); c_rx_data = (bi < 80) ? rb[bi] : 8'h0;
      h_out_ready = 1; #1;
      if (c_rx_valid && c_rx_ready) bi++;
      if (h_out_valid) begin
        chk("R4 drained word", h_out_data, word_of(rb, 4 * wi, 80));
        wi++;
      end
      guard++;
      @(negedge clk);
    end
    c_rx_valid = 0; h_out_ready = 0;
    repeat (2) @(negedge clk);
    chk("R8 off after read", 32'(ctrl_q), 32'h02);
    chk("R7 end after read", 32'(status), ST_END);

    // R7/R8 zero length
    wr_len(16'd0); wr_ctrl(8'h01);
    @(negedge clk);
    chk("R8 zero length self-off", 32'(ctrl_q), 0);
    chk("R7 zero length end flags", 32'(status), ST_END);

    // R5 partial words, R2 mode bits without effect
    run_rx(5, 100, 100, 8'h00);
    run_rx(4, 100, 100, 8'h0C);
    run_tx(6, 100, 8'h00);
    run_tx(5, 100, 8'h0C);

    // random mix
    for (int r = 0; r < 14; r++) begin
      int len = 1 + ($urandom % 70);
      if ($urandom % 2) run_rx(len, 30 + $urandom % 70, 30 + $urandom % 70, 8'($urandom % 4) << 2);
      else run_tx(len, 30 + $urandom % 70, 8'($urandom % 4) << 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule